// File: doc/BRIEF.md
# USB Host Port Reset and Status Controller

This block holds the status and bus-reset logic for one downstream port of a USB host controller. Software reaches it through an 8-bit port control/status word. It reports when a device attaches or detaches. On a software request it drives the bus reset, and it times that reset entirely in hardware. When the reset finishes, the port becomes enabled and software is notified through a port-change interrupt request.

The reset length is counted in transceiver clock cycles. The default counts give 10 ms at 60 MHz, which covers 8-bit parallel and full-speed serial PHY modes, and 10 ms at 30 MHz, which covers 16-bit PHY mode. The mode field is latched at the moment a reset starts. Software only has to write a 1 to start a reset. Any write that tries to end the reset early is ignored. The port is always owned by this controller, so low- and full-speed devices attach to it directly.

Top module: `usb_port_reset_ctl`

## Requirements
- R1: Bit 0 of `psc` follows `dev_attach` one clock late. Any change of `dev_attach` sets the connect-change bit, bit 1, on the next clock.
- R2: With no reset in progress and no detach in the same cycle, a write with bit 4 set starts a bus reset. From the next clock, `bus_reset` and bit 4 read 1 and the enable bit (bit 2) reads 0.
- R3: A started reset keeps `bus_reset` high for exactly `FAST_CYCLES` clocks, or `SLOW_CYCLES` clocks in 16-bit mode. Software does not need to act for the reset to end.
- R4: During a reset, writing 0 to bit 4 does not end the reset, and writing 1 to bit 4 does not restart it.
- R5: On the clock where a reset completes, `bus_reset` and bit 4 fall, the enable bit rises and the enable-change bit (bit 3) is set.
- R6: The owner bit (bit 5) always reads 0, whatever is written to it.
- R7: The mode field (bits 7:6) is read/write. Value 01 selects 16-bit mode (SLOW_CYCLES); every other value selects FAST_CYCLES. The mode is taken from the write that starts the reset, and later mode writes do not change a reset that is running.
- R8: Bits 1 and 3 are write-1-to-clear. When an event and a clearing write arrive in the same cycle, the bit stays set.
- R9: `irq` equals `irq_en` AND (bit 1 OR bit 3), with no delay.
- R10: A detach during a reset aborts the reset on the next clock. That clock clears `bus_reset` and the enable bit and sets the connect-change bit, and it does not set the enable-change bit. A detach at any other time also clears the enable bit.
- R11: After reset, `psc` reads 0, `bus_reset` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transceiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the port control/status word |
| wr_data | input | 8 | Write data: [7:6] mode, [4] reset, [3] and [1] clear-on-one |
| dev_attach | input | 1 | Device-present indication from the link layer |
| irq_en | input | 1 | Port-change interrupt enable |
| psc | output | 8 | {mode, owner=0, reset, en_chg, en, conn_chg, conn} |
| bus_reset | output | 1 | Bus reset drive to the port |
| irq | output | 1 | Port-change interrupt request |

## Verification
The assertions assume that `dev_attach` is synchronous to `clk` and that it holds steady between clock edges. They also assume that `wr_en` and `wr_data` change only away from the active edge. The bench meets these assumptions by driving every input on the falling edge. It also overrides the count parameters with short values, so that complete resets, aborted resets and mode changes in the middle of a reset all fit within the run.

// File: rtl/usb_port_reset_ctl.sv
module usb_port_reset_ctl #(
  parameter int unsigned FAST_CYCLES = 600000,
  parameter int unsigned SLOW_CYCLES = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       dev_attach,
  input  logic       irq_en,
  output logic [7:0] psc,
  output logic       bus_reset,
  output logic       irq
);
  localparam int unsigned MAXC = (FAST_CYCLES > SLOW_CYCLES) ? FAST_CYCLES : SLOW_CYCLES;
  localparam int CW = $clog2(MAXC) + 1;
  localparam logic [1:0] MODE_WIDE = 2'b01;

  logic          conn, cc, en, ec, busy;
  logic [1:0]    mode;
  logic [CW-1:0] cnt, lim;

  wire attach_ev = dev_attach ^ conn;
  wire detach_ev = conn & ~dev_attach;
  wire start     = wr_en & wr_data[4] & ~busy & ~detach_ev;
  wire at_end    = busy && (cnt == lim - CW'(1));
  wire done      = at_end & ~detach_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn <= 1'b0;
      cc   <= 1'b0;
      ec   <= 1'b0;
      en   <= 1'b0;
      busy <= 1'b0;
      mode <= 2'b00;
      cnt  <= '0;
      lim  <= '0;
    end else begin
      conn <= dev_attach;
      cc   <= (cc & ~(wr_en & wr_data[1])) | attach_ev;
      ec   <= (ec & ~(wr_en & wr_data[3])) | done;
      if (wr_en) mode <= wr_data[7:6];
      if (detach_ev) begin
        busy <= 1'b0;
        en   <= 1'b0;
      end else if (busy) begin
        if (at_end) begin
          busy <= 1'b0;
          en   <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (start) begin
        busy <= 1'b1;
        en   <= 1'b0;
        cnt  <= '0;
        lim  <= (wr_data[7:6] == MODE_WIDE) ? CW'(SLOW_CYCLES) : CW'(FAST_CYCLES);
      end
    end
  end

  assign psc       = {mode, 1'b0, busy, ec, en, cc, conn};
  assign bus_reset = busy;
  assign irq       = irq_en & (cc | ec);

  assert_attach_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_attach != psc[0]) |=> psc[1]);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4] && !bus_reset && !(psc[0] && !dev_attach)) |=> (bus_reset && !psc[2]));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < lim));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !at_end && !(psc[0] && !dev_attach)) |=> bus_reset);

  assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !(psc[0] && !dev_attach)) |=> (!bus_reset && psc[2] && psc[3]));

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (psc[1] || psc[3])));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && psc[0] && !dev_attach) |=> (!bus_reset && !psc[2] && psc[1]));
endmodule

// File: tb/sim_usb_port_reset_ctl.sv
module sim_usb_port_reset_ctl;
  localparam int FAST = 24;
  localparam int SLOW = 12;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, dev_attach = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] psc;
  logic bus_reset, irq;

  int checks = 0, errors = 0;

  usb_port_reset_ctl #(.FAST_CYCLES(FAST), .SLOW_CYCLES(SLOW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dev_attach(dev_attach), .irq_en(irq_en), .psc(psc),
    .bus_reset(bus_reset), .irq(irq));

  always #2 clk = ~clk;

  // behavioural reference
  bit m_conn, m_cc, m_en, m_ec, m_rst;
  bit [1:0] m_mode;
  int m_left;

  always @(posedge clk) begin
    bit ev, det, ncc, nec, nen, nrst;
    int nleft;
    if (!rst_n) begin
      m_conn = 0; m_cc = 0; m_en = 0; m_ec = 0; m_rst = 0; m_mode = 0; m_left = 0;
    end else begin
      ev  = (dev_attach != m_conn);
      det = m_conn && !dev_attach;
      ncc = (m_cc && !(wr_en && wr_data[1])) || ev;
      nec = m_ec && !(wr_en && wr_data[3]);
      nen = m_en; nrst = m_rst; nleft = m_left;
      if (det) begin
        nrst = 0; nen = 0;
      end else if (m_rst) begin
        nleft = m_left - 1;
        if (nleft == 0) begin nrst = 0; nen = 1; nec = 1; end
      end else if (wr_en && wr_data[4]) begin
        nrst = 1; nen = 0;
        nleft = (wr_data[7:6] == 2'b01) ? SLOW : FAST;
      end
      if (wr_en) m_mode = wr_data[7:6];
      m_conn = dev_attach; m_cc = ncc; m_ec = nec; m_en = nen; m_rst = nrst; m_left = nleft;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R1 conn", {31'd0, psc[0]}, {31'd0, m_conn});
    check("R1/R8 conn_chg", {31'd0, psc[1]}, {31'd0, m_cc});
    check("R5 enable", {31'd0, psc[2]}, {31'd0, m_en});
    check("R5/R8 en_chg", {31'd0, psc[3]}, {31'd0, m_ec});
    check("R2/R3 reset bit", {31'd0, psc[4]}, {31'd0, m_rst});
    check("R3 bus_reset", {31'd0, bus_reset}, {31'd0, m_rst});
    check("R6 owner", {31'd0, psc[5]}, 32'd0);
    check("R7 mode", {30'd0, psc[7:6]}, {30'd0, m_mode});
    check("R9 irq", {31'd0, irq}, {31'd0, irq_en && (m_cc || m_ec)});
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    check("R11 psc", {24'd0, psc}, 32'd0);
    check("R11 bus_reset", {31'd0, bus_reset}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    irq_en = 1'b1;
    dev_attach = 1'b1;
    idle(2);
    check("R1 conn_chg set", {31'd0, psc[1]}, 32'd1);
    check("R9 irq on connect", {31'd0, irq}, 32'd1);
    wr(8'h22);
    check("R6 owner write ignored", {31'd0, psc[5]}, 32'd0);
    check("R8 conn_chg cleared", {31'd0, psc[1]}, 32'd0);

    // fast reset with early-end, restart and mode writes in the middle
    wr(8'h10);
    n = 0;
    for (int i = 0; i < FAST + 4; i++) begin
      if (bus_reset) n++;
      if (i == 5)  begin wr_en = 1'b1; wr_data = 8'h00; end
      else if (i == 8)  begin wr_en = 1'b1; wr_data = 8'h10; end
      else if (i == 11) begin wr_en = 1'b1; wr_data = 8'h40; end
      else begin wr_en = 1'b0; wr_data = 8'h00; end
      @(negedge clk);
    end
    check("R4/R7 fast length with writes", n, FAST);
    check("R5 enabled after reset", {31'd0, psc[2]}, 32'd1);
    check("R5 en_chg after reset", {31'd0, psc[3]}, 32'd1);

    wr(8'h08);
    check("R8 en_chg cleared", {31'd0, psc[3]}, 32'd0);

    // slow reset
    wr(8'h50);
    n = 0;
    while (bus_reset && n < 100) begin n++; @(negedge clk); end
    check("R3 slow length", n, SLOW);

    // event and clear in the same cycle
    wr(8'h08);
    dev_attach = 1'b0;
    wr(8'h02);
    check("R8 event beats clear", {31'd0, psc[1]}, 32'd1);
    check("R10 detach disables", {31'd0, psc[2]}, 32'd0);
    wr(8'h02);

    // detach during reset
    dev_attach = 1'b1;
    idle(2);
    wr(8'h12);
    idle(4);
    dev_attach = 1'b0;
    @(negedge clk);
    check("R10 abort", {31'd0, bus_reset}, 32'd0);
    check("R10 no en_chg", {31'd0, psc[3]}, 32'd0);
    irq_en = 1'b0;
    @(negedge clk);
    check("R9 gated", {31'd0, irq}, 32'd0);

    // mixed stimulus
    for (int i = 0; i < 600; i++) begin
      if ((i % 37) == 0) dev_attach = ~dev_attach;
      if ((i % 11) == 3) begin wr_en = 1'b1; wr_data = 8'(i * 29); end
      else begin wr_en = 1'b0; wr_data = 8'h00; end
      if ((i % 50) == 0) irq_en = ~irq_en;
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule